// File: doc/BRIEF.md
# Chip-Select Watchdog Reset Supervisor

This block generates a system reset from four causes: a power-up stretch that follows the supply becoming good, a supply-low flag from an external comparator, reset levels forced onto the two reset pins from outside, and a watchdog timer that is kicked by activity on the serial-bus chip select. Every flop runs on one system clock. All timing is set by parameters in clock cycles, so one netlist can cover real-time values and short test values.

Both reset pins are modelled as open-drain drive enables. The active-high pin is driven high, and the active-low pin is driven low, while the internal reset state is set. When reset is released both enables go to 0, and board pull resistors set the pin levels. The asynchronous supply inputs and pin-level inputs pass through synchronizers before use. The supply flag also passes a glitch filter. The filtered supply-low level drives the write-inhibit output, which blocks array and status writes in the memory next to this block.

Top module: `rstSupervisor`

## Requirements
- R1: While `rstN` is low and just after it rises, both drive enables read 1 and `writeInhibit` reads 1. The filtered supply level starts as not good.
- R2: Each input passes a two-flop synchronizer. A supply-good level that survives the filter holds the reset state for exactly `RST_CYC` clock cycles after the filter accepts it, and the reset state then releases. From the `supplyOk` rising edge to the release is 2 + `GLITCH_CYC` + `RST_CYC` rising clock edges.
- R3: A change on `supplyOk` that lasts fewer than `GLITCH_CYC` consecutive synchronized cycles never reaches the filtered level. It has no effect on the reset state or on `writeInhibit`.
- R4: When the filtered supply level is low, `writeInhibit` is 1, and the reset state is set one cycle later and held. The stretch counter stays at zero until the supply is good again.
- R5: A high level on `extRstHi` holds the reset state. After the level is removed, the full `RST_CYC` period runs again from zero.
- R6: A low level on `extRstLo` behaves like R5.
- R7: With `wdSel` set to 0, 1 or 2, the watchdog limits are `WD_CYC0`, `WD_CYC1` and `WD_CYC2`. When the released block sees that many cycles in a row with no chip-select transition, it sets the reset state. The reset then runs its full `RST_CYC` period.
- R8: A rising or a falling transition on `csN` returns the watchdog count to zero.
- R9: With `wdSel` equal to 3, the watchdog never counts and never causes a reset.
- R10: While the reset state is set, the watchdog count stays at zero. After a release, the full limit is needed before the next watchdog reset.
- R11: `rstHiDrive` and `rstLoDrive` always equal the reset state, and both are 0 when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset of the logic |
| supplyOk | input | 1 | Supply-good flag from the external comparator, asynchronous |
| csN | input | 1 | Serial-bus chip select, active low, asynchronous |
| extRstHi | input | 1 | Level read back from the active-high reset pin |
| extRstLo | input | 1 | Level read back from the active-low reset pin |
| wdSel | input | 2 | Watchdog period select; 3 disables |
| rstHiDrive | output | 1 | Drive-high enable of the active-high reset pin |
| rstLoDrive | output | 1 | Drive-low enable of the active-low reset pin |
| writeInhibit | output | 1 | Filtered supply-low, blocks memory and status writes |

## Verification
The bench builds the block with `GLITCH_CYC` 4, `RST_CYC` 40 and watchdog limits of 120, 80 and 50 cycles. With these values every supply stretch, pin-forced restart and watchdog expiry completes within a few hundred cycles. Every watchdog code can therefore be run to expiry and then kicked just before its limit. Glitches of one to three cycles can be placed around the filter length, and a trigger can be made to arrive while a stretch is already running.

// File: rtl/rsvPkg.sv
package rsvPkg;

  // Strobes and levels passed from control to datapath each cycle
  typedef struct packed {
    logic       supplyLow;  // filtered supply is not good
    logic       extHold;    // an external pin forces reset
    logic       csEdge;     // chip select changed level
    logic       wdOff;      // watchdog disabled by code 3
    logic [1:0] wdSel;      // period select
  } rsvStrobeT;

  localparam logic [1:0] WD_DISABLED = 2'b11;

endpackage

// File: rtl/rsvCtrl.sv
module rsvCtrl
  import rsvPkg::*;
#(
  parameter int GLITCH_CYC  = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       csN,
  input  logic       extRstHi,
  input  logic       extRstLo,
  input  logic [1:0] wdSel,
  output rsvStrobeT  strobes
);

  localparam int N_IN = 4;
  localparam int GC_W = $clog2(GLITCH_CYC + 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'(GLITCH_CYC - 1);
  // bit order: extRstLo, extRstHi, csN, supplyOk
  localparam logic [N_IN-1:0] SYNC_INIT = 4'b1010;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncPipe [SYNC_STAGES];
  logic [N_IN-1:0] syncOut;

  assign rawIn = {extRstLo, extRstHi, csN, supplyOk};

  genvar st;
  generate
    for (st = 0; st < SYNC_STAGES; st++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncPipe[st] <= SYNC_INIT;
        end else if (st == 0) begin
          syncPipe[st] <= rawIn;
        end else begin
          syncPipe[st] <= syncPipe[(st == 0) ? 0 : st-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncPipe[SYNC_STAGES-1];

  // Glitch filter: the level is accepted after GLITCH_CYC equal cycles
  logic            supplyFilt;
  logic [GC_W-1:0] glitchCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supplyFilt <= 1'b0;
      glitchCnt  <= '0;
    end else if (syncOut[0] == supplyFilt) begin
      glitchCnt <= '0;
    end else if (glitchCnt == GC_LAST) begin
      supplyFilt <= syncOut[0];
      glitchCnt  <= '0;
    end else begin
      glitchCnt <= glitchCnt + 1'b1;
    end
  end

  // Chip-select transition detect
  logic csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b1;
    else       csPrev <= syncOut[1];
  end

  always_comb begin
    strobes.supplyLow = ~supplyFilt;
    strobes.extHold   = syncOut[2] | ~syncOut[3];
    strobes.csEdge    = syncOut[1] ^ csPrev;
    strobes.wdOff     = (wdSel == WD_DISABLED);
    strobes.wdSel     = wdSel;
  end

endmodule

// File: rtl/rsvDatapath.sv
module rsvDatapath
  import rsvPkg::*;
#(
  parameter int RST_CYC = 50_000_000,
  parameter int WD_CYC0 = 350_000_000,
  parameter int WD_CYC1 = 150_000_000,
  parameter int WD_CYC2 = 50_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  rsvStrobeT strobes,
  output logic      rstOn,
  output logic [$clog2(RST_CYC+1)-1:0] stretchCnt,
  output logic [$clog2(((WD_CYC0 > WD_CYC1) ? ((WD_CYC0 > WD_CYC2) ? WD_CYC0 : WD_CYC2)
                                           : ((WD_CYC1 > WD_CYC2) ? WD_CYC1 : WD_CYC2)) + 1)-1:0] wdCnt
);

  localparam int WD_MAX = (WD_CYC0 > WD_CYC1) ? ((WD_CYC0 > WD_CYC2) ? WD_CYC0 : WD_CYC2)
                                              : ((WD_CYC1 > WD_CYC2) ? WD_CYC1 : WD_CYC2);
  localparam int ST_W = $clog2(RST_CYC + 1);
  localparam int WD_W = $clog2(WD_MAX + 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(RST_CYC - 1);

  logic [WD_W-1:0] wdLast;
  logic            holdCond;
  logic            wdHit;
  logic            wdClear;

  always_comb begin
    unique case (strobes.wdSel)
      2'd0:    wdLast = WD_W'(WD_CYC0 - 1);
      2'd1:    wdLast = WD_W'(WD_CYC1 - 1);
      2'd2:    wdLast = WD_W'(WD_CYC2 - 1);
      default: wdLast = '1;
    endcase
  end

  assign holdCond = strobes.supplyLow | strobes.extHold;
  assign wdClear  = rstOn | holdCond | strobes.csEdge | strobes.wdOff;
  assign wdHit    = ~wdClear & (wdCnt == wdLast);

  // Reset state and stretch counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstOn      <= 1'b1;
      stretchCnt <= '0;
    end else if (holdCond) begin
      rstOn      <= 1'b1;
      stretchCnt <= '0;
    end else if (rstOn) begin
      if (stretchCnt == ST_LAST) begin
        rstOn      <= 1'b0;
        stretchCnt <= '0;
      end else begin
        stretchCnt <= stretchCnt + 1'b1;
      end
    end else if (wdHit) begin
      rstOn      <= 1'b1;
      stretchCnt <= '0;
    end
  end

  // Watchdog counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (wdClear || wdHit) begin
      wdCnt <= '0;
    end else begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

endmodule

// File: rtl/rstSupervisor.sv
module rstSupervisor
  import rsvPkg::*;
#(
  parameter int GLITCH_CYC = 25,
  parameter int RST_CYC    = 50_000_000,
  parameter int WD_CYC0    = 350_000_000,
  parameter int WD_CYC1    = 150_000_000,
  parameter int WD_CYC2    = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       csN,
  input  logic       extRstHi,
  input  logic       extRstLo,
  input  logic [1:0] wdSel,
  output logic       rstHiDrive,
  output logic       rstLoDrive,
  output logic       writeInhibit
);

  localparam int WD_MAX = (WD_CYC0 > WD_CYC1) ? ((WD_CYC0 > WD_CYC2) ? WD_CYC0 : WD_CYC2)
                                              : ((WD_CYC1 > WD_CYC2) ? WD_CYC1 : WD_CYC2);
  localparam int ST_W = $clog2(RST_CYC + 1);
  localparam int WD_W = $clog2(WD_MAX + 1);

  rsvStrobeT       strobes;
  logic            rstOn;
  logic [ST_W-1:0] stretchCnt;
  logic [WD_W-1:0] wdCnt;

  rsvCtrl #(
    .GLITCH_CYC (GLITCH_CYC),
    .SYNC_STAGES(2)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .csN     (csN),
    .extRstHi(extRstHi),
    .extRstLo(extRstLo),
    .wdSel   (wdSel),
    .strobes (strobes)
  );

  rsvDatapath #(
    .RST_CYC(RST_CYC),
    .WD_CYC0(WD_CYC0),
    .WD_CYC1(WD_CYC1),
    .WD_CYC2(WD_CYC2)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rstOn     (rstOn),
    .stretchCnt(stretchCnt),
    .wdCnt     (wdCnt)
  );

  assign rstHiDrive   = rstOn;
  assign rstLoDrive   = rstOn;
  assign writeInhibit = strobes.supplyLow;

endmodule

// File: rtl/rsvChecker.sv
module rsvChecker #(
  parameter int RST_CYC = 40,
  parameter int ST_W    = 6,
  parameter int WD_W    = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            extRstHi,
  input logic            extRstLo,
  input logic [1:0]      wdSel,
  input logic            rstHiDrive,
  input logic            rstLoDrive,
  input logic            writeInhibit,
  input logic            csEdge,
  input logic [ST_W-1:0] stretchCnt,
  input logic [WD_W-1:0] wdCnt
);

  logic [1:0] upCyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCyc <= '0;
    else if (upCyc != 2'd3) upCyc <= upCyc + 1'b1;
  end

  // R4
  supply_low_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeInhibit |=> rstHiDrive);

  // R5
  ext_hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCyc == 2'd3 && extRstHi && $past(extRstHi) && $past(extRstHi, 2)) |=> rstHiDrive);

  // R6
  ext_lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCyc == 2'd3 && !extRstLo && !$past(extRstLo) && !$past(extRstLo, 2)) |=> rstLoDrive);

  // R2
  stretch_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstHiDrive) |-> ($past(stretchCnt) == ST_W'(RST_CYC - 1)));

  // R8
  cs_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    csEdge |=> (wdCnt == '0));

  // R9
  wd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdSel == 2'b11) |=> (wdCnt == '0));

  // R10
  wd_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstHiDrive |=> (wdCnt == '0));

  // R11
  pins_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstHiDrive == rstLoDrive);

endmodule

bind rstSupervisor rsvChecker #(
  .RST_CYC(RST_CYC),
  .ST_W   (ST_W),
  .WD_W   (WD_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .extRstHi    (extRstHi),
  .extRstLo    (extRstLo),
  .wdSel       (wdSel),
  .rstHiDrive  (rstHiDrive),
  .rstLoDrive  (rstLoDrive),
  .writeInhibit(writeInhibit),
  .csEdge      (strobes.csEdge),
  .stretchCnt  (stretchCnt),
  .wdCnt       (wdCnt)
);

// File: tb/tb_rstSupervisor.sv
module tb_rstSupervisor;

  localparam int G   = 4;
  localparam int RST = 40;
  localparam int W0  = 120;
  localparam int W1  = 80;
  localparam int W2  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic csN = 1'b1;
  logic extRstHi = 1'b0;
  logic extRstLo = 1'b1;
  logic [1:0] wdSel = 2'd1;
  logic rstHiDrive, rstLoDrive, writeInhibit;

  always #2 clk = ~clk;

  rstSupervisor #(
    .GLITCH_CYC(G), .RST_CYC(RST), .WD_CYC0(W0), .WD_CYC1(W1), .WD_CYC2(W2)
  ) dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .csN(csN),
    .extRstHi(extRstHi), .extRstLo(extRstLo), .wdSel(wdSel),
    .rstHiDrive(rstHiDrive), .rstLoDrive(rstLoDrive), .writeInhibit(writeInhibit)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit sawRst = 0;
  bit done = 0;

  // Behavioural reference state
  bit mSup[2], mCs[2], mHi[2], mLo[2];
  bit mFilt, mCsPrev, mRst;
  int mGc, mSt, mWd;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int wdLimit(input logic [1:0] s);
    case (s)
      2'd0: return W0;
      2'd1: return W1;
      2'd2: return W2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSup = '{0, 0}; mCs = '{1, 1}; mHi = '{0, 0}; mLo = '{1, 1};
      mFilt = 0; mCsPrev = 1; mRst = 1; mGc = 0; mSt = 0; mWd = 0;
    end else begin
      bit hold, kick, off, hit, oldRst;
      hold = !mFilt || mHi[1] || !mLo[1];
      kick = (mCs[1] != mCsPrev);
      off  = (wdSel == 2'd3);
      oldRst = mRst;
      hit = !oldRst && !hold && !kick && !off && (mWd == wdLimit(wdSel) - 1);
      if (hold) begin mRst = 1; mSt = 0; end
      else if (mRst) begin
        if (mSt == RST - 1) begin mRst = 0; mSt = 0; end
        else mSt++;
      end else if (hit) begin mRst = 1; mSt = 0; end
      if (oldRst || hold || kick || off || hit) mWd = 0;
      else mWd++;
      if (mSup[1] == mFilt) mGc = 0;
      else if (mGc == G - 1) begin mFilt = mSup[1]; mGc = 0; end
      else mGc++;
      mCsPrev = mCs[1];
      mSup[1] = mSup[0]; mSup[0] = supplyOk;
      mCs[1] = mCs[0];   mCs[0] = csN;
      mHi[1] = mHi[0];   mHi[0] = extRstHi;
      mLo[1] = mLo[0];   mLo[0] = extRstLo;
    end
  end

  // Compare against the reference every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, rstHiDrive, mRst, "rstHiDrive vs model");
      check("R11", rstLoDrive, rstHiDrive, "rstLoDrive vs rstHiDrive");
      check(curReq, writeInhibit, !mFilt, "writeInhibit vs model");
      if (rstHiDrive) sawRst = 1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRelease();
    for (int i = 0; i < 400 && rstHiDrive; i++) step(1);
  endtask

  initial begin
    step(3);
    check("R1", rstHiDrive, 1, "drive-high during reset");
    check("R1", writeInhibit, 1, "inhibit during reset");
    rstN = 1'b1;
    step(1);
    check("R1", rstLoDrive, 1, "drive-low after reset");

    // R3: short supply glitches
    curReq = "R3";
    for (int w = 1; w < G; w++) begin
      supplyOk = 1'b1; step(w); supplyOk = 1'b0; step(10);
      check("R3", writeInhibit, 1, "inhibit after short glitch");
    end

    // R2: exact stretch length
    curReq = "R2";
    supplyOk = 1'b1;
    step(2 + G + RST - 1);
    check("R2", rstHiDrive, 1, "still in reset one edge before release");
    step(1);
    check("R2", rstHiDrive, 0, "released after full stretch");
    check("R11", rstLoDrive, 0, "low pin released");

    // R3: glitch low on a good supply
    curReq = "R3";
    supplyOk = 1'b0; step(G - 1); supplyOk = 1'b1; step(8);
    check("R3", writeInhibit, 0, "short dropout ignored");
    check("R3", rstHiDrive, 0, "short dropout caused no reset");

    // R8: kicks on both edges with code 1 (limit 80)
    curReq = "R8";
    sawRst = 0;
    for (int k = 0; k < 6; k++) begin
      step(W1 - 15); csN = ~csN;
    end
    step(5);
    check("R8", sawRst, 0, "kicks on both edges prevented reset");

    // R7: starve each code and check expiry
    for (int c = 0; c < 3; c++) begin
      curReq = "R7";
      wdSel = 2'(c);
      sawRst = 0;
      step(wdLimit(2'(c)) + 10);
      check("R7", sawRst, 1, "watchdog expiry asserted reset");
      waitRelease();
      // R10: full limit is needed again after release
      curReq = "R10";
      sawRst = 0;
      step(wdLimit(2'(c)) - 3);
      check("R10", sawRst, 0, "no early expiry after release");
      waitRelease();
      step(RST + 5);
      waitRelease();
    end

    // R9: disabled watchdog
    curReq = "R9";
    wdSel = 2'd3;
    step(2);
    sawRst = 0;
    step(3 * W0);
    check("R9", sawRst, 0, "disabled watchdog never resets");

    // R5: external high level restarts the period, also mid-stretch
    curReq = "R5";
    extRstHi = 1'b1; step(10); extRstHi = 1'b0;
    step(20);
    extRstHi = 1'b1; step(3); extRstHi = 1'b0;
    step(RST - 5);
    check("R5", rstHiDrive, 1, "period restarted by second pulse");
    step(20);
    check("R5", rstHiDrive, 0, "released after restart");

    // R6: external low level
    curReq = "R6";
    extRstLo = 1'b0; step(10); extRstLo = 1'b1;
    step(RST - 5);
    check("R6", rstLoDrive, 1, "still held after low pulse");
    step(20);
    check("R6", rstLoDrive, 0, "released after low pulse");

    // R4: supply drop
    curReq = "R4";
    supplyOk = 1'b0;
    step(2 + G + 2);
    check("R4", writeInhibit, 1, "inhibit after supply drop");
    check("R4", rstHiDrive, 1, "reset after supply drop");
    step(100);
    check("R4", rstHiDrive, 1, "reset held while supply low");
    supplyOk = 1'b1;
    step(2 + G + RST + 3);
    check("R4", rstHiDrive, 0, "released after supply returns");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule